// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a byte-wide nonvolatile memory. It watches the memory's chip-select and write-enable pins, samples the clock-domain image of those pins, and turns each completed bus write into a command byte with an address. Destructive operations need two writes in a fixed order. The first write is a setup code and the second is the matching execute write. A few single-write commands switch the read path or cancel a pending sequence.

Once an execute write is accepted, the block sends a one-cycle strobe to a generic storage array: program one byte, erase one sector, or erase the whole array. It then holds a busy state for a time set by a parameter in clock cycles. Reads are strobed on `rd_i`. Depending on the mode, the read byte is array data, an identification code, or a status byte that software can poll until the operation ends. An external `protect_i` flag blocks every destructive operation.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode, `busy_o` is 0, no array strobe is active and `rdata_o` is 00h.
- R2: A bus write is active while `cs_ni` and `we_ni` are both low. The address is sampled in the first clock where both are low, which is the later of the two falling edges. The data is sampled in the first clock where either is high again, which is the earlier rising edge. That same clock ends the write.
- R3: Writing 20h then D0h pulses `arr_erase_sec_o` for one cycle. `arr_addr_o` carries the execute write's address with its low SB bits (default 8, so 256-byte sectors) forced to zero.
- R4: Writing 10h then any byte other than FFh pulses `arr_prog_o` for one cycle. `arr_addr_o` is the second write's address and `arr_wdata_o` is its data.
- R5: Writing 30h then 30h pulses `arr_erase_all_o` for one cycle with `arr_addr_o` = 0.
- R6: A write of FFh in any setup state returns the block to array-read mode with no strobe.
- R7: A setup code followed by a byte other than its execute code returns the block to array-read mode with no strobe. In array-read mode, bytes that are not command codes are ignored.
- R8: A write of 90h enters identification mode. In this mode a read of address 0 returns BFh, a read of address 1 returns 04h, and a read of any other address returns 00h. The mode survives reads and non-command bytes. FFh or any setup code leaves it.
- R9: While `protect_i` is 1, an execute write produces no strobe and returns the block to array-read mode. FFh and 90h still work.
- R10: After a strobe, `busy_o` is high for exactly PROG_CYC, SECT_CYC or CHIP_CYC clock cycles (program, sector erase, chip erase). The block then returns to array-read mode by itself.
- R11: A read while busy returns a status byte. Bit 7 is the complement of bit 7 of the byte being written (the program data, or FFh for an erase). Bit 6 is 0 on the first read after a start and inverts on every further read. Bits 5:0 are `arr_rdata_i[5:0]`.
- R12: While busy, writes other than FFh are ignored and leave no pending setup. A write of FFh ends the busy state in the cycle after the write completes.
- R13: `rdata_o` takes its new value in the cycle after `rd_i` is sampled high and holds that value until the next read. In array-read mode the value is `arr_rdata_i` for the address presented with `rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | AW | Bus address for writes and reads |
| wdata_i | input | 8 | Bus write data |
| rd_i | input | 1 | Read strobe, one cycle |
| protect_i | input | 1 | Blocks program and erase when high |
| rdata_o | output | 8 | Registered read data |
| busy_o | output | 1 | Timed operation in progress |
| arr_raddr_o | output | AW | Array read address (follows `addr_i`) |
| arr_rdata_i | input | 8 | Array read data for `arr_raddr_o` |
| arr_prog_o | output | 1 | Program-byte strobe |
| arr_erase_sec_o | output | 1 | Erase-sector strobe |
| arr_erase_all_o | output | 1 | Erase-all strobe |
| arr_addr_o | output | AW | Operation address |
| arr_wdata_o | output | 8 | Program data (FFh for erases) |

## Verification
The bench aims at the abort and mismatch paths. A sequencer that left a setup pending after FFh, a wrong execute code or a write ignored while busy would turn the next harmless byte into a program or erase strobe, and the strobe scoreboard reports any such strobe as unexpected. Skewed bus writes are driven with the address and data changing during the active window, and a write driven by chip select with write enable already low is also driven. A latch on the wrong edge would program the wrong location or the wrong byte. Busy length is counted per operation to catch an off-by-one in the counter. Status reads check that bit 6 starts at 0 after a start and inverts on each read, so a free-running toggle or one that is never cleared fails.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_ARRAY,
    ST_IDENT,
    ST_SU_SECT,
    ST_SU_PROG,
    ST_SU_CHIP,
    ST_BUSY
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_PROG,
    OP_ESECT,
    OP_EALL
  } arr_op_e;

  localparam logic [7:0] CMD_SECT_SU = 8'h20;
  localparam logic [7:0] CMD_SECT_GO = 8'hD0;
  localparam logic [7:0] CMD_PROG_SU = 8'h10;
  localparam logic [7:0] CMD_CHIP_SU = 8'h30;
  localparam logic [7:0] CMD_CHIP_GO = 8'h30;
  localparam logic [7:0] CMD_ABORT   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;

  localparam logic [7:0] ID_VENDOR   = 8'hBF;
  localparam logic [7:0] ID_PART     = 8'h04;

endpackage

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
  parameter int AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);

  logic          act, act_q;
  logic [AW-1:0] addr_q;

  assign act = !cs_ni && !we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      addr_q    <= '0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      act_q    <= act;
      wr_stb_o <= act_q && !act;
      // address on the later falling edge, data on the earlier rising edge
      if (act && !act_q) addr_q <= addr_i;
      if (act_q && !act) begin
        wr_addr_o <= addr_q;
        wr_data_o <= wdata_i;
      end
    end
  end

  a_r2_commit_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !act) |=> wr_stb_o);

  a_r2_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          clear_i,
  output logic          done_o,
  output logic          run_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign run_o  = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1)) && !clear_i;

  a_r12_clear_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !run_o);

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int AW       = 19,
  parameter int SB       = 8,
  parameter int CW       = 12,
  parameter int PROG_CYC = 40,
  parameter int SECT_CYC = 400,
  parameter int CHIP_CYC = 2000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          protect_i,
  input  logic          tmr_done_i,
  input  logic          tmr_run_i,
  output seq_state_e    state_o,
  output logic          start_o,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          tmr_clear_o,
  output logic          arr_prog_o,
  output logic          arr_erase_sec_o,
  output logic          arr_erase_all_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [7:0]    arr_wdata_o
);

  localparam logic [CW-1:0] PROG_LD = CW'(PROG_CYC);
  localparam logic [CW-1:0] SECT_LD = CW'(SECT_CYC);
  localparam logic [CW-1:0] CHIP_LD = CW'(CHIP_CYC);

  seq_state_e st_q, st_d;
  arr_op_e    op;

  always_comb begin
    st_d        = st_q;
    op          = OP_NONE;
    tmr_clear_o = 1'b0;
    unique case (st_q)
      ST_ARRAY, ST_IDENT: if (wr_stb_i) begin
        unique case (wr_data_i)
          CMD_SECT_SU: st_d = ST_SU_SECT;
          CMD_PROG_SU: st_d = ST_SU_PROG;
          CMD_CHIP_SU: st_d = ST_SU_CHIP;
          CMD_IDENT:   st_d = ST_IDENT;
          CMD_ABORT:   st_d = ST_ARRAY;
          default:     st_d = st_q;
        endcase
      end
      ST_SU_SECT: if (wr_stb_i) begin
        st_d = ST_ARRAY;
        if (wr_data_i == CMD_SECT_GO && !protect_i) op = OP_ESECT;
      end
      ST_SU_PROG: if (wr_stb_i) begin
        st_d = ST_ARRAY;
        if (wr_data_i != CMD_ABORT && !protect_i) op = OP_PROG;
      end
      ST_SU_CHIP: if (wr_stb_i) begin
        st_d = ST_ARRAY;
        if (wr_data_i == CMD_CHIP_GO && !protect_i) op = OP_EALL;
      end
      ST_BUSY: begin
        if (wr_stb_i && wr_data_i == CMD_ABORT) begin
          st_d        = ST_ARRAY;
          tmr_clear_o = 1'b1;
        end else if (tmr_done_i) begin
          st_d = ST_ARRAY;
        end
      end
      default: st_d = ST_ARRAY;
    endcase
    if (op != OP_NONE) st_d = ST_BUSY;
  end

  assign start_o    = (op != OP_NONE);
  assign tmr_load_o = start_o;
  always_comb begin
    unique case (op)
      OP_PROG:  tmr_val_o = PROG_LD;
      OP_ESECT: tmr_val_o = SECT_LD;
      OP_EALL:  tmr_val_o = CHIP_LD;
      default:  tmr_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q            <= ST_ARRAY;
      arr_prog_o      <= 1'b0;
      arr_erase_sec_o <= 1'b0;
      arr_erase_all_o <= 1'b0;
      arr_addr_o      <= '0;
      arr_wdata_o     <= '0;
    end else begin
      st_q            <= st_d;
      arr_prog_o      <= (op == OP_PROG);
      arr_erase_sec_o <= (op == OP_ESECT);
      arr_erase_all_o <= (op == OP_EALL);
      if (op != OP_NONE) begin
        unique case (op)
          OP_ESECT: arr_addr_o <= {wr_addr_i[AW-1:SB], {SB{1'b0}}};
          OP_EALL:  arr_addr_o <= '0;
          default:  arr_addr_o <= wr_addr_i;
        endcase
        arr_wdata_o <= (op == OP_PROG) ? wr_data_i : 8'hFF;
      end
    end
  end

  assign state_o = st_q;

  a_r3_onehot_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({arr_prog_o, arr_erase_sec_o, arr_erase_all_o}));

  a_r9_protect_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && protect_i && st_q != ST_BUSY)
      |=> !(arr_prog_o || arr_erase_sec_o || arr_erase_all_o));

  a_r6_abort_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && wr_data_i == CMD_ABORT &&
     (st_q == ST_SU_SECT || st_q == ST_SU_PROG || st_q == ST_SU_CHIP))
      |=> (st_q == ST_ARRAY && !arr_prog_o && !arr_erase_sec_o && !arr_erase_all_o));

  a_r10_busy_has_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY) |-> tmr_run_i);

  a_r10_idle_no_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_BUSY) |-> !tmr_run_i);

  a_r12_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY && wr_stb_i && wr_data_i != CMD_ABORT && !tmr_done_i)
      |=> (st_q == ST_BUSY && !arr_prog_o && !arr_erase_sec_o && !arr_erase_all_o));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW       = 19,
  parameter int SB       = 8,
  parameter int PROG_CYC = 40,
  parameter int SECT_CYC = 400,
  parameter int CHIP_CYC = 2000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          rd_i,
  input  logic          protect_i,
  output logic [7:0]    rdata_o,
  output logic          busy_o,
  output logic [AW-1:0] arr_raddr_o,
  input  logic [7:0]    arr_rdata_i,
  output logic          arr_prog_o,
  output logic          arr_erase_sec_o,
  output logic          arr_erase_all_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [7:0]    arr_wdata_o
);

  localparam int MAX_SE  = (SECT_CYC > PROG_CYC) ? SECT_CYC : PROG_CYC;
  localparam int MAX_CYC = (CHIP_CYC > MAX_SE) ? CHIP_CYC : MAX_SE;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  seq_state_e    state;
  logic          start, tmr_load, tmr_clear, tmr_done, tmr_run;
  logic [CW-1:0] tmr_val;
  logic          tog_q;
  logic [7:0]    id_byte;

  flash_wr_capture #(.AW(AW)) u_cap (
    .clk_i, .rst_ni, .cs_ni, .we_ni, .addr_i, .wdata_i,
    .wr_stb_o (wr_stb),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  flash_cmd_fsm #(
    .AW(AW), .SB(SB), .CW(CW),
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_fsm (
    .clk_i, .rst_ni,
    .wr_stb_i   (wr_stb),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .protect_i,
    .tmr_done_i (tmr_done),
    .tmr_run_i  (tmr_run),
    .state_o    (state),
    .start_o    (start),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .tmr_clear_o(tmr_clear),
    .arr_prog_o, .arr_erase_sec_o, .arr_erase_all_o,
    .arr_addr_o, .arr_wdata_o
  );

  flash_op_timer #(.CW(CW)) u_tmr (
    .clk_i, .rst_ni,
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .clear_i   (tmr_clear),
    .done_o    (tmr_done),
    .run_o     (tmr_run)
  );

  assign busy_o      = (state == ST_BUSY);
  assign arr_raddr_o = addr_i;
  assign id_byte     = (addr_i[AW-1:1] != '0) ? 8'h00 :
                       (addr_i[0] ? ID_PART : ID_VENDOR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (start)                tog_q <= 1'b0;
      else if (rd_i && busy_o)  tog_q <= ~tog_q;
      if (rd_i) begin
        if (busy_o)                rdata_o <= {~arr_wdata_o[7], tog_q, arr_rdata_i[5:0]};
        else if (state == ST_IDENT) rdata_o <= id_byte;
        else                        rdata_o <= arr_rdata_i;
      end
    end
  end

  a_r13_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  a_r11_toggle_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_o && $past(rd_i && busy_o) && !start) |=> (rdata_o[6] != $past(rdata_o[6])));

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  localparam int AW = 12, SB = 8, PC = 12, SC = 20, CC = 30;
  localparam int K_PROG = 1, K_SECT = 2, K_ALL = 3;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          cs_ni = 1'b1, we_ni = 1'b1, rd_i = 1'b0, protect_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o, arr_rdata_i, arr_wdata_o;
  logic          busy_o, arr_prog_o, arr_erase_sec_o, arr_erase_all_o;
  logic [AW-1:0] arr_raddr_o, arr_addr_o;

  logic [7:0] mem [1 << AW];
  int checks = 0, errors = 0;
  string cur_tag = "R1";
  bit tog_exp = 1'b0;

  int    q_kind[$], q_addr[$], q_data[$];
  string q_tag[$];
  int    r_exp[$];
  string r_tag[$];
  logic  rd_seen = 1'b0;

  always #5 clk = ~clk;

  assign arr_rdata_i = mem[arr_raddr_o];

  flash_cmd_seq #(.AW(AW), .SB(SB), .PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC)) u_dut (
    .clk_i(clk), .rst_ni, .cs_ni, .we_ni, .addr_i, .wdata_i, .rd_i, .protect_i,
    .rdata_o, .busy_o, .arr_raddr_o, .arr_rdata_i, .arr_prog_o, .arr_erase_sec_o,
    .arr_erase_all_o, .arr_addr_o, .arr_wdata_o
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // strobe monitor / scoreboard with the array model
  always @(negedge clk) begin
    if (arr_prog_o || arr_erase_sec_o || arr_erase_all_o) begin
      int k;
      k = arr_prog_o ? K_PROG : (arr_erase_sec_o ? K_SECT : K_ALL);
      if (q_kind.size() == 0) begin
        check(1'b0, {cur_tag, " unexpected strobe"}, k, 0);
      end else begin
        int ek, ea, ed;
        string t;
        ek = q_kind.pop_front(); ea = q_addr.pop_front();
        ed = q_data.pop_front(); t = q_tag.pop_front();
        check(k == ek, {t, " strobe kind"}, k, ek);
        check(int'(arr_addr_o) == ea, {t, " op address"}, int'(arr_addr_o), ea);
        if (k == K_PROG) check(int'(arr_wdata_o) == ed, {t, " op data"}, int'(arr_wdata_o), ed);
      end
      if (arr_prog_o) mem[arr_addr_o] = mem[arr_addr_o] & arr_wdata_o;
      else if (arr_erase_sec_o) begin
        for (int i = 0; i < (1 << SB); i++) mem[int'(arr_addr_o) + i] = 8'hFF;
      end else begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
      end
    end
  end

  // read monitor
  always @(posedge clk) rd_seen <= rd_i;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (r_exp.size() == 0) check(1'b0, {cur_tag, " unexpected read"}, int'(rdata_o), 0);
      else begin
        int e;
        string t;
        e = r_exp.pop_front(); t = r_tag.pop_front();
        check(int'(rdata_o) == e, {t, " read data"}, int'(rdata_o), e);
      end
    end
  end

  task automatic expect_op(int kind, int addr, int data);
    q_kind.push_back(kind); q_addr.push_back(addr);
    q_data.push_back(data); q_tag.push_back(cur_tag);
    tog_exp = 1'b0;
  endtask

  task automatic bus_wr(int addr, int data);
    @(negedge clk); cs_ni = 1'b0; we_ni = 1'b0; addr_i = AW'(addr); wdata_i = 8'(data);
    @(negedge clk); we_ni = 1'b1;
    @(negedge clk); cs_ni = 1'b1;
  endtask

  task automatic rd(int addr, int exp);
    @(negedge clk); rd_i = 1'b1; addr_i = AW'(addr);
    r_exp.push_back(exp); r_tag.push_back(cur_tag);
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic status_rd(int addr, int pdata);
    int e;
    e = {~pdata[7], tog_exp, mem[addr][5:0]};
    rd(addr, e);
    tog_exp = ~tog_exp;
  endtask

  task automatic busy_len(int exp);
    int n = 0;
    @(negedge clk);
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
    check(n == exp, {cur_tag, " busy length"}, n, exp);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  task automatic drained();
    repeat (3) @(negedge clk);
    check(q_kind.size() == 0, {cur_tag, " expected strobe missing"}, q_kind.size(), 0);
    check(busy_o == 1'b0, {cur_tag, " idle"}, int'(busy_o), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    cur_tag = "R1";
    check(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
    check(rdata_o == 8'h00, "R1 rdata", int'(rdata_o), 0);
    check({arr_prog_o, arr_erase_sec_o, arr_erase_all_o} == 3'b000, "R1 strobes",
          int'({arr_prog_o, arr_erase_sec_o, arr_erase_all_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R13 array reads and hold
    cur_tag = "R13";
    rd(5, mem[5]);
    rd(100, mem[100]);
    repeat (3) @(negedge clk);
    check(int'(rdata_o) == int'(mem[100]), "R13 hold", int'(rdata_o), int'(mem[100]));

    // R4 program, R11 status while busy
    cur_tag = "R4";
    bus_wr(0, 8'h10);
    expect_op(K_PROG, 12'h123, 8'h3C);
    bus_wr(12'h123, 8'h3C);
    @(negedge clk);
    cur_tag = "R11";
    status_rd(12'h123, 8'h3C);
    status_rd(12'h123, 8'h3C);
    status_rd(12'h456, 8'h3C);
    wait_idle();
    cur_tag = "R4";
    rd(12'h123, mem[12'h123]);

    // R3 sector erase, R10 length
    cur_tag = "R3";
    bus_wr(0, 8'h20);
    expect_op(K_SECT, 12'h300, 0);
    bus_wr(12'h3A7, 8'hD0);
    cur_tag = "R10";
    busy_len(SC);
    cur_tag = "R3";
    rd(12'h3A7, 8'hFF);

    // R5 chip erase, R10 length
    cur_tag = "R5";
    bus_wr(0, 8'h30);
    expect_op(K_ALL, 0, 0);
    bus_wr(12'h777, 8'h30);
    cur_tag = "R10";
    busy_len(CC);
    cur_tag = "R5";
    rd(12'hABC, 8'hFF);

    // R10 program length, R11 on erased cell with bit7 = 0
    cur_tag = "R10";
    bus_wr(0, 8'h10);
    expect_op(K_PROG, 12'h010, 8'h5A);
    bus_wr(12'h010, 8'h5A);
    busy_len(PC);
    cur_tag = "R11";
    bus_wr(0, 8'h20);
    expect_op(K_SECT, 12'hE00, 0);
    bus_wr(12'hE55, 8'hD0);
    @(negedge clk);
    status_rd(12'hE55, 8'hFF);
    status_rd(12'hE55, 8'hFF);
    wait_idle();

    // R6 abort after each setup
    cur_tag = "R6";
    bus_wr(0, 8'h20); bus_wr(0, 8'hFF);
    bus_wr(0, 8'h10); bus_wr(12'h011, 8'hFF);
    bus_wr(0, 8'h30); bus_wr(0, 8'hFF);
    rd(12'h010, mem[12'h010]);
    drained();

    // R7 mismatched execute codes, stray bytes
    cur_tag = "R7";
    bus_wr(0, 8'h20); bus_wr(12'h010, 8'h55);
    bus_wr(0, 8'h30); bus_wr(0, 8'h31);
    bus_wr(12'h010, 8'hD0);
    bus_wr(12'h010, 8'h30);
    bus_wr(12'h010, 8'hFF);
    rd(12'h010, mem[12'h010]);
    drained();

    // R8 identification mode
    cur_tag = "R8";
    bus_wr(0, 8'h90);
    rd(0, 8'hBF);
    rd(1, 8'h04);
    rd(5, 8'h00);
    bus_wr(0, 8'h55);
    rd(0, 8'hBF);
    bus_wr(0, 8'hFF);
    rd(0, mem[0]);
    bus_wr(0, 8'h90);
    bus_wr(0, 8'h10);
    expect_op(K_PROG, 12'h020, 8'h81);
    bus_wr(12'h020, 8'h81);
    wait_idle();
    rd(1, mem[1]);

    // R9 protection
    cur_tag = "R9";
    protect_i = 1'b1;
    bus_wr(0, 8'h10); bus_wr(12'h030, 8'h42);
    bus_wr(0, 8'h20); bus_wr(12'h030, 8'hD0);
    bus_wr(0, 8'h30); bus_wr(0, 8'h30);
    rd(12'h030, mem[12'h030]);
    bus_wr(0, 8'h90);
    rd(1, 8'h04);
    bus_wr(0, 8'hFF);
    rd(1, mem[1]);
    drained();
    protect_i = 1'b0;

    // R12 writes during busy
    cur_tag = "R12";
    bus_wr(0, 8'h30);
    expect_op(K_ALL, 0, 0);
    bus_wr(0, 8'h30);
    repeat (3) @(negedge clk);
    bus_wr(0, 8'h10);
    @(negedge clk);
    check(busy_o == 1'b1, "R12 still busy after ignored write", int'(busy_o), 1);
    bus_wr(0, 8'hFF);
    @(negedge clk);
    check(busy_o == 1'b0, "R12 abort ends busy", int'(busy_o), 0);
    bus_wr(12'h040, 8'h55);
    drained();

    // R2 skewed write: address from first active cycle, data from last
    cur_tag = "R2";
    bus_wr(0, 8'h10);
    expect_op(K_PROG, 12'h210, 8'h81);
    @(negedge clk); cs_ni = 1'b0; we_ni = 1'b0; addr_i = 12'h210; wdata_i = 8'h11;
    @(negedge clk); addr_i = 12'h2FF; wdata_i = 8'h81;
    @(negedge clk); we_ni = 1'b1;
    @(negedge clk); cs_ni = 1'b1;
    wait_idle();
    // chip-select controlled: write enable falls first
    bus_wr(0, 8'h10);
    expect_op(K_PROG, 12'h220, 8'h66);
    @(negedge clk); we_ni = 1'b0; addr_i = 12'h999; wdata_i = 8'h00;
    @(negedge clk); cs_ni = 1'b0; addr_i = 12'h220;
    @(negedge clk); addr_i = 12'h3FF; wdata_i = 8'h66;
    @(negedge clk); cs_ni = 1'b1;
    @(negedge clk); we_ni = 1'b1;
    wait_idle();
    drained();
    check(r_exp.size() == 0, "R13 reads all returned", r_exp.size(), 0);

    finish_run();
  end

endmodule